// File: doc/BRIEF.md
# Accumulator Processor Core

A small processor core built around one accumulator register. Every instruction word names at most one memory location. The accumulator is always the other source and the destination. The core holds a program counter, an instruction register, the accumulator and four condition flags: negative, zero, overflow and carry. It executes from a single word-wide memory inside the block, which serves both instructions and data. Every instruction takes two clock cycles. The first cycle fetches the instruction register from the location the program counter points to. The second cycle decodes that register and carries out the operation.

The surrounding logic fills the memory through a write port while the core is held in reset. It then releases reset and waits for the halted output. A read-only inspection port returns any memory word without disturbing the core, so results that were stored can be read back afterwards. Arithmetic is two's complement. Subtraction is performed as addition of the inverted operand with a carry-in of one.

Top module: `acc_core`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, pc_o, acc_o and flags_o are zero and halted_o is low.
- R2: An instruction word carries its opcode in bits 31:28 and a byte operand address in bits ADDR_W-1:0, which selects memory word address[ADDR_W-1:2]. Each instruction takes a fetch cycle and then an execute cycle. The fetch cycle adds 4 to pc_o.
- R3: LOAD (opcode 1) copies the addressed word into the accumulator and updates N and Z. V and C keep their values.
- R4: STORE (opcode 2) writes the accumulator to the addressed word. The accumulator and all flags are left unchanged.
- R5: ADD (opcode 3) adds the addressed word to the accumulator. C is the carry out of the top bit. V is the carry into the top bit XOR the carry out of it, so operands of opposite sign never set V.
- R6: SUB (opcode 4) forms accumulator + ~word + 1. The carry out of the top bit is dropped from the result and reported in C, which is 1 when no borrow occurs. V follows the rule in R5.
- R7: BR (opcode 5) always loads pc_o with the operand address.
- R8: BZ (6), BN (7) and BV (8) load pc_o with the operand address when Z, N or V respectively is set. Otherwise execution continues at the next instruction. No branch changes the flags.
- R9: HALT (15) stops the fetch/execute sequence and raises halted_o. From then until reset, pc_o, acc_o, flags_o and memory do not change.
- R10: Opcodes 0 and 9 to 14 do nothing except advance to the next instruction.
- R11: flags_o is {N,Z,V,C} from bit 3 down to bit 0. After LOAD, ADD or SUB, N equals the top bit of the new accumulator value and Z is set exactly when that value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_we_i | input | 1 | Write enable for filling memory |
| load_addr_i | input | ADDR_W | Byte address of the word to fill |
| load_data_i | input | DATA_W | Word to write |
| peek_addr_i | input | ADDR_W | Byte address for inspection |
| peek_data_o | output | DATA_W | Memory word at peek_addr_i |
| pc_o | output | ADDR_W | Program counter |
| acc_o | output | DATA_W | Accumulator |
| flags_o | output | 4 | {N,Z,V,C} |
| halted_o | output | 1 | High after HALT executes |

## Verification
The overflow and carry flags are the hardest to observe. They appear only after an ADD or SUB whose operands drive a carry into or out of the sign bit, and a later LOAD must leave them untouched. The stimulus programs therefore use boundary operands: the largest positive value plus one, two negative values whose sum wraps to positive, and a small positive value minus the most negative value. Each program then tests the resulting flags with taken and not-taken conditional branches. The end state is checked through the accumulator, the flags, the program counter and memory words read back through the peek port.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [3:0] {
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_BR    = 4'd5,
    OP_BZ    = 4'd6,
    OP_BN    = 4'd7,
    OP_BV    = 4'd8,
    OP_HALT  = 4'd15
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_HALT  = 2'd2
  } state_e;
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              ext_we_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [DATA_W-1:0] ext_wdata_i,
  input  logic              core_we_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic [DATA_W-1:0] core_rdata_o,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [DATA_W-1:0] peek_rdata_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int WORDS = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              wr_en;

  // fill port wins over a core store
  always_comb begin
    wr_en   = ext_we_i | core_we_i;
    wr_idx  = ext_we_i ? ext_addr_i[ADDR_W-1:2] : core_addr_i[ADDR_W-1:2];
    wr_data = ext_we_i ? ext_wdata_i : core_wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign core_rdata_o = mem_q[core_addr_i[ADDR_W-1:2]];
  assign peek_rdata_o = mem_q[peek_addr_i[ADDR_W-1:2]];
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-2:0] low_sum;
  logic              c_into_msb;
  logic              msb_sum;
  logic              c_out_msb;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    {c_into_msb, low_sum} = {1'b0, a_i[DATA_W-2:0]} + {1'b0, b_eff[DATA_W-2:0]}
                            + {{(DATA_W-1){1'b0}}, sub_i};
    {c_out_msb, msb_sum}  = {1'b0, a_i[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]}
                            + {1'b0, c_into_msb};
    sum_o   = {msb_sum, low_sum};
    carry_o = c_out_msb;
    ovf_o   = c_into_msb ^ c_out_msb;
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] alu_a_o,
  output logic              alu_sub_o,
  input  logic [DATA_W-1:0] alu_sum_i,
  input  logic              alu_c_i,
  input  logic              alu_v_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output flags_t            flags_o,
  output logic              exec_o,
  output logic              halted_o,
  output logic [DATA_W-1:0] ir_o
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(4);

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;
  flags_t            flags_q;
  op_e               op;
  logic [ADDR_W-1:0] operand;

  assign op      = op_e'(ir_q[DATA_W-1:DATA_W-4]);
  assign operand = ir_q[ADDR_W-1:0];

  always_comb begin
    mem_addr_o  = (state_q == ST_EXEC) ? operand : pc_q;
    mem_we_o    = (state_q == ST_EXEC) && (op == OP_STORE);
    mem_wdata_o = acc_q;
    alu_a_o     = acc_q;
    alu_sub_o   = (op == OP_SUB);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      flags_q <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: begin
          ir_q    <= mem_rdata_i;
          pc_q    <= pc_q + PC_STEP;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          state_q <= ST_FETCH;
          case (op)
            OP_LOAD: begin
              acc_q     <= mem_rdata_i;
              flags_q.n <= mem_rdata_i[DATA_W-1];
              flags_q.z <= (mem_rdata_i == '0);
            end
            OP_ADD, OP_SUB: begin
              acc_q   <= alu_sum_i;
              flags_q <= '{n: alu_sum_i[DATA_W-1], z: (alu_sum_i == '0),
                           v: alu_v_i, c: alu_c_i};
            end
            OP_BR: pc_q <= operand;
            OP_BZ: if (flags_q.z) pc_q <= operand;
            OP_BN: if (flags_q.n) pc_q <= operand;
            OP_BV: if (flags_q.v) pc_q <= operand;
            OP_HALT: state_q <= ST_HALT;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign acc_o    = acc_q;
  assign flags_o  = flags_q;
  assign exec_o   = (state_q == ST_EXEC);
  assign halted_o = (state_q == ST_HALT);
  assign ir_o     = ir_q;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [DATA_W-1:0] peek_data_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [3:0]        flags_o,
  output logic              halted_o
);
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] alu_a;
  logic              alu_sub;
  logic [DATA_W-1:0] alu_sum;
  logic              alu_c;
  logic              alu_v;
  flags_t            flags;
  logic              exec_w;
  logic [DATA_W-1:0] ir_w;

  acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i       (clk_i),
    .ext_we_i    (load_we_i),
    .ext_addr_i  (load_addr_i),
    .ext_wdata_i (load_data_i),
    .core_we_i   (mem_we),
    .core_addr_i (mem_addr),
    .core_wdata_i(mem_wdata),
    .core_rdata_o(mem_rdata),
    .peek_addr_i (peek_addr_i),
    .peek_rdata_o(peek_data_o)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i    (alu_a),
    .b_i    (mem_rdata),
    .sub_i  (alu_sub),
    .sum_o  (alu_sum),
    .carry_o(alu_c),
    .ovf_o  (alu_v)
  );

  acc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mem_rdata_i(mem_rdata),
    .mem_addr_o (mem_addr),
    .mem_we_o   (mem_we),
    .mem_wdata_o(mem_wdata),
    .alu_a_o    (alu_a),
    .alu_sub_o  (alu_sub),
    .alu_sum_i  (alu_sum),
    .alu_c_i    (alu_c),
    .alu_v_i    (alu_v),
    .pc_o       (pc_o),
    .acc_o      (acc_o),
    .flags_o    (flags),
    .exec_o     (exec_w),
    .halted_o   (halted_o),
    .ir_o       (ir_w)
  );

  assign flags_o = flags;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [3:0]        flags_o,
  input logic              halted_o,
  input logic              exec_phase,
  input logic [DATA_W-1:0] ir_word
);
  logic [3:0] opc;
  assign opc = ir_word[DATA_W-1:DATA_W-4];

  p_fetch_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_phase && !halted_o) |=> (exec_phase && pc_o == $past(pc_o) + ADDR_W'(4)));

  p_exec_to_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_phase |=> !exec_phase);

  p_load_keeps_vc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_phase && opc == 4'd1) |=> (flags_o[1:0] == $past(flags_o[1:0])));

  p_store_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_phase && opc == 4'd2) |=> ($stable(acc_o) && $stable(flags_o)));

  p_branch_always_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_phase && opc == 4'd5) |=> (pc_o == $past(ir_word[ADDR_W-1:0])));

  p_bz_not_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_phase && opc == 4'd6 && !flags_o[2]) |=> ($stable(pc_o) && $stable(flags_o)));

  p_halt_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o) && $stable(acc_o) && $stable(flags_o)));

  p_unused_op_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_phase && (opc == 4'd0 || (opc >= 4'd9 && opc <= 4'd14)))
      |=> ($stable(pc_o) && $stable(acc_o) && $stable(flags_o) && !halted_o));

  p_nz_match_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_phase && (opc == 4'd1 || opc == 4'd3 || opc == 4'd4))
      |=> (flags_o[3] == acc_o[DATA_W-1] && flags_o[2] == (acc_o == '0)));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_o      (pc_o),
  .acc_o     (acc_o),
  .flags_o   (flags_o),
  .halted_o  (halted_o),
  .exec_phase(exec_w),
  .ir_word   (ir_w)
);

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_we_i = 1'b0;
  logic [ADDR_W-1:0] load_addr_i = '0;
  logic [DATA_W-1:0] load_data_i = '0;
  logic [ADDR_W-1:0] peek_addr_i = '0;
  logic [DATA_W-1:0] peek_data_o;
  logic [ADDR_W-1:0] pc_o;
  logic [DATA_W-1:0] acc_o;
  logic [3:0]        flags_o;
  logic              halted_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          kind;   // 0 acc, 1 flags, 2 pc, 3 memory word
    logic [31:0] arg;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #2.5 clk_i = ~clk_i;

  acc_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (.*);

  function automatic logic [31:0] ins(input int op, input int addr);
    return (32'(op) << 28) | 32'(addr);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int addr, input logic [31:0] data);
    @(negedge clk_i);
    load_we_i = 1'b1; load_addr_i = ADDR_W'(addr); load_data_i = data;
    @(negedge clk_i);
    load_we_i = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1 << ADDR_W); i += 4) put(i, 32'h0);
  endtask

  task automatic want(input int kind, input int arg, input logic [31:0] exp, input string req);
    item_t it;
    it.kind = kind; it.arg = 32'(arg); it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic go_and_drain();
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait (sb.size() == 0);
    @(negedge clk_i);
  endtask

  // monitor: compares queued expectations once the core halts
  initial begin
    forever begin
      @(posedge halted_o);
      @(negedge clk_i);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = acc_o;
          1: act = {28'h0, flags_o};
          2: act = {24'h0, pc_o};
          default: begin
            peek_addr_i = ADDR_W'(it.arg);
            #0.1;
            act = peek_data_o;
          end
        endcase
        check(it.req, act, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Program A: ADD overflow and carry, STORE, fetch timing
    rst_ni = 1'b0;
    clear_mem();
    check("R1 pc in reset", {24'h0, pc_o}, 32'h0);
    check("R1 acc in reset", acc_o, 32'h0);
    check("R1 flags in reset", {28'h0, flags_o}, 32'h0);
    check("R1 halted in reset", {31'h0, halted_o}, 32'h0);
    put(8'h80, 32'h7FFF_FFFF);
    put(8'h84, 32'h0000_0001);
    put(8'h88, 32'hFFFF_FFFF);
    put(8'h00, ins(1, 8'h80));
    put(8'h04, ins(3, 8'h84));
    put(8'h08, ins(2, 8'h90));
    put(8'h0C, ins(3, 8'h88));
    put(8'h10, ins(2, 8'h94));
    put(8'h14, ins(15, 0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2 pc after first fetch", {24'h0, pc_o}, 32'h4);
    check("R2 acc unchanged in fetch", acc_o, 32'h0);
    @(negedge clk_i);
    check("R3 acc after LOAD execute", acc_o, 32'h7FFF_FFFF);
    check("R11 flags after positive LOAD", {28'h0, flags_o}, 32'h0);
    repeat (9) @(negedge clk_i);
    check("R2 not halted before cycle 12", {31'h0, halted_o}, 32'h0);
    want(0, 0, 32'h7FFF_FFFF, "R5 acc after negative wrap add");
    want(1, 0, 32'h3, "R5 flags V and C after neg+neg");
    want(2, 0, 32'h18, "R9 pc after HALT");
    want(3, 8'h90, 32'h8000_0000, "R4 R5 stored max+1");
    want(3, 8'h94, 32'h7FFF_FFFF, "R4 stored second sum");
    wait (sb.size() == 0);
    @(negedge clk_i);

    // Program B: SUB, conditional branches taken and not taken
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 pc back to zero", {24'h0, pc_o}, 32'h0);
    check("R1 halted cleared", {31'h0, halted_o}, 32'h0);
    clear_mem();
    put(8'h80, 32'd5);
    put(8'h84, 32'd5);
    put(8'h88, 32'd3);
    put(8'h8C, 32'h8000_0000);
    put(8'h00, ins(1, 8'h80));
    put(8'h04, ins(4, 8'h84));
    put(8'h08, ins(6, 8'h14));
    put(8'h0C, ins(2, 8'h98));
    put(8'h10, ins(15, 0));
    put(8'h14, ins(1, 8'h88));
    put(8'h18, ins(4, 8'h8C));
    put(8'h1C, ins(8, 8'h28));
    put(8'h20, ins(15, 0));
    put(8'h24, ins(15, 0));
    put(8'h28, ins(7, 8'h30));
    put(8'h2C, ins(15, 0));
    put(8'h30, ins(6, 8'h20));
    put(8'h34, ins(2, 8'h9C));
    put(8'h38, ins(15, 0));
    want(0, 0, 32'h8000_0003, "R6 acc after 3 minus min");
    want(1, 0, 32'hA, "R6 flags N V set C clear");
    want(2, 0, 32'h3C, "R8 pc after taken and untaken branches");
    want(3, 8'h9C, 32'h8000_0003, "R8 store after untaken BZ");
    want(3, 8'h98, 32'h0, "R8 taken BZ skipped store");
    go_and_drain();

    // Program C: unconditional branch, unused opcodes, HALT freeze
    rst_ni = 1'b0;
    clear_mem();
    put(8'h80, 32'hFFFF_FFF0);
    put(8'h00, ins(1, 8'h80));
    put(8'h04, ins(9, 8'h84));
    put(8'h08, ins(5, 8'h10));
    put(8'h0C, ins(15, 0));
    put(8'h10, ins(0, 8'h80));
    put(8'h14, ins(2, 8'hA0));
    put(8'h18, ins(15, 0));
    put(8'h1C, ins(2, 8'hA4));
    want(0, 0, 32'hFFFF_FFF0, "R10 acc kept across unused opcodes");
    want(1, 0, 32'h8, "R11 N after negative LOAD");
    want(2, 0, 32'h1C, "R7 pc after BR path");
    want(3, 8'hA0, 32'hFFFF_FFF0, "R7 store on branch target path");
    go_and_drain();
    repeat (10) @(negedge clk_i);
    check("R9 halted held", {31'h0, halted_o}, 32'h1);
    check("R9 pc frozen", {24'h0, pc_o}, 32'h1C);
    peek_addr_i = 8'hA4;
    #0.1;
    check("R9 no store after HALT", peek_data_o, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule